// File: doc/BRIEF.md
# Policy-selectable data cache controller

This block is a direct-mapped data cache controller. It sits between a processor port that moves one word per request and a memory port that moves whole lines, or a single word with byte enables. It holds the tag, valid and dirty state, the line storage, and the state machine that handles misses, refills, victim writebacks and direct word writes.

A static mode input picks the write policy. In write-back mode, write hits stay in the cache and mark the line dirty. A write miss fetches the line and merges the data into it. Dirty victims go back to memory before the new line is fetched. In write-through mode, every write goes to memory as a single-word write. A write hit also updates the cached copy. A write miss leaves the cache untouched.

A flush request walks all lines, writes back the dirty ones, and reports completion with a one-cycle pulse. The change of mode is meant to happen only while reset is held.

Addresses on both ports are word addresses. The low two bits select the word inside a four-word line, the next four bits select one of 16 lines, and the rest form the tag.

Top module: `dcache_ctrl`

## Requirements
- R1: A read that hits completes in the first cycle after the request is taken: `cpuReady` is high in the cycle after `cpuValid` is first seen in idle, and `cpuRdata` holds the stored word. No memory request is made.
- R2: In write-through mode (`wbMode`=0), a write hit updates the cached word. It also issues exactly one word write (`memOp`=2) carrying the request's address, data and byte enables. No line is ever written back in this mode.
- R3: In write-back mode (`wbMode`=1), a write hit updates only the cached word and marks the line dirty. No memory request is made.
- R4: In write-back mode, a miss whose victim line is valid and dirty first issues a line write (`memOp`=1) of the victim at the victim's own line address. It then issues a line read (`memOp`=0) of the requested line.
- R5: A miss whose victim line is clean or invalid issues only the line read of the requested line, in either mode.
- R6: In write-back mode, a write miss reads the whole line from memory and installs it. It then merges the write into it. No memory write is issued for that request, and a later read of the address returns the merged word.
- R7: In write-through mode, a write miss issues only a word write to memory. The line that was resident at that index stays resident and still hits, and the missed address stays uncached.
- R8: In write-back mode, any number of writes to a resident line produce no memory traffic. The memory receives the last written value only when the line is evicted.
- R9: Byte enable bit b (one bit per byte lane, bit 0 = bits 7:0) selects which bytes of the write data are used. This holds both when merging into a cached line and in a word write to memory; disabled bytes keep their previous value.
- R10: A one-cycle pulse on `flushReq` in idle starts a walk over all lines. Each dirty line is written back once, in ascending index order. All dirty marks are cleared, but lines stay valid. `flushDone` is high for exactly one cycle at the end. A second flush with no intervening writes issues no memory traffic.
- R11: After reset `cpuReady`, `memReq` and `flushDone` are low. `cpuReady` is never high while a memory request is outstanding. A memory request keeps its operation until `memAck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wbMode | input | 1 | 1 = write-back with allocate on write miss, 0 = write-through without allocate |
| cpuValid | input | 1 | Processor request present; held with its fields until `cpuReady` |
| cpuWrite | input | 1 | 1 = write request, 0 = read request |
| cpuAddr | input | ADDR_W (10) | Word address: tag, line index, word in line |
| cpuWdata | input | WORD_W (32) | Write data |
| cpuBe | input | WORD_W/8 (4) | Byte enables for writes |
| cpuReady | output | 1 | Request completes in this cycle |
| cpuRdata | output | WORD_W (32) | Read data, valid while `cpuReady` is high on a read |
| flushReq | input | 1 | Start a flush walk (sampled in idle) |
| flushDone | output | 1 | One-cycle pulse when the walk ends |
| memReq | output | 1 | Memory request, held until `memAck` |
| memOp | output | 2 | 0 = line read, 1 = line write, 2 = word write |
| memAddr | output | ADDR_W (10) | Word address; line-aligned for line operations |
| memWline | output | LINE_WORDS*WORD_W (128) | Line data for line writes, word 0 in the low bits |
| memWword | output | WORD_W (32) | Data for word writes |
| memBe | output | WORD_W/8 (4) | Byte enables for word writes |
| memAck | input | 1 | One-cycle completion of the current memory request |
| memRline | input | LINE_WORDS*WORD_W (128) | Line read data, valid with `memAck` |

## Verification
The bench drives directed sequences against a memory model that logs every memory operation with its address. Each request's outcome is then told apart by the exact list of operations it caused.

Reads and writes go to a cold index, to a clean victim and to a dirty victim in each mode, which separates fetch-only misses from writeback-then-fetch misses and allocating from non-allocating write misses. Repeated writes to one line followed by a conflicting read show whether writes were absorbed and whether the final value reaches memory. Partial byte-enable patterns on both a cached merge and a direct word write show lane selection. Two back-to-back flushes, followed by a hit and a conflicting miss, distinguish writing back and clearing dirty marks from invalidating.

// File: rtl/dcache_pkg.sv
package dcache_pkg;

  typedef enum logic [1:0] {
    MEM_LINE_RD = 2'd0,
    MEM_LINE_WR = 2'd1,
    MEM_WORD_WR = 2'd2
  } memop_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COMPARE,
    ST_WRITEBACK,
    ST_REFILL,
    ST_MEM_WRITE,
    ST_FLUSH
  } state_e;

  // Write strobes from control to datapath
  typedef struct packed {
    logic installLine;  // load refilled line, set valid, clear dirty
    logic mergeWord;    // merge request word into line under byte enables
    logic setDirty;     // mark requested line dirty
    logic clearDirty;   // clear dirty mark of selected line
  } dp_strobe_t;

endpackage

// File: rtl/dcache_dp.sv
module dcache_dp
  import dcache_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int NUM_LINES  = 16,
  localparam int BeW   = WORD_W / 8,
  localparam int WselW = $clog2(LINE_WORDS),
  localparam int IdxW  = $clog2(NUM_LINES),
  localparam int TagW  = ADDR_W - IdxW - WselW,
  localparam int LineW = WORD_W * LINE_WORDS
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        strobe,
  input  logic              selFlush,
  input  logic [IdxW-1:0]   flushIdx,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [WORD_W-1:0] cpuWdata,
  input  logic [BeW-1:0]    cpuBe,
  input  logic [LineW-1:0]  memRline,
  output logic              hit,
  output logic              victimDirty,
  output logic [ADDR_W-1:0] victimAddr,
  output logic [LineW-1:0]  lineData,
  output logic [WORD_W-1:0] rdWord
);

  logic [WORD_W-1:0] dataArr [NUM_LINES][LINE_WORDS];
  logic [TagW-1:0]   tagArr  [NUM_LINES];
  logic [NUM_LINES-1:0] validArr;
  logic [NUM_LINES-1:0] dirtyArr;

  logic [TagW-1:0]   reqTag;
  logic [IdxW-1:0]   reqIdx;
  logic [WselW-1:0]  reqWord;
  logic [IdxW-1:0]   selIdx;
  logic [WORD_W-1:0] oldWord;
  logic [WORD_W-1:0] newWord;

  assign reqWord = cpuAddr[WselW-1:0];
  assign reqIdx  = cpuAddr[WselW +: IdxW];
  assign reqTag  = cpuAddr[ADDR_W-1 -: TagW];
  assign selIdx  = selFlush ? flushIdx : reqIdx;

  assign hit         = validArr[reqIdx] && (tagArr[reqIdx] == reqTag);
  assign victimDirty = validArr[selIdx] && dirtyArr[selIdx];
  assign victimAddr  = {tagArr[selIdx], selIdx, {WselW{1'b0}}};

  assign oldWord = dataArr[reqIdx][reqWord];
  assign rdWord  = oldWord;

  // Byte-lane merge of the request word
  for (genvar b = 0; b < BeW; b++) begin : gLane
    assign newWord[b*8 +: 8] = cpuBe[b] ? cpuWdata[b*8 +: 8] : oldWord[b*8 +: 8];
  end

  // Packed view of the selected line for line writes
  for (genvar w = 0; w < LINE_WORDS; w++) begin : gPack
    assign lineData[w*WORD_W +: WORD_W] = dataArr[selIdx][w];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validArr <= '0;
      dirtyArr <= '0;
    end else begin
      if (strobe.installLine) begin
        validArr[reqIdx] <= 1'b1;
        dirtyArr[reqIdx] <= 1'b0;
      end
      if (strobe.setDirty)   dirtyArr[reqIdx] <= 1'b1;
      if (strobe.clearDirty) dirtyArr[selIdx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.installLine) begin
      tagArr[reqIdx] <= reqTag;
      for (int w = 0; w < LINE_WORDS; w++) begin
        dataArr[reqIdx][w] <= memRline[w*WORD_W +: WORD_W];
      end
    end
    if (strobe.mergeWord) dataArr[reqIdx][reqWord] <= newWord;
  end

  AST_MERGE_ON_HIT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.mergeWord |-> hit);  // R9
  AST_INSTALL_HITS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.installLine |=> hit);  // R6

endmodule

// File: rtl/dcache_ctl.sv
module dcache_ctl
  import dcache_pkg::*;
#(
  parameter int NUM_LINES = 16,
  localparam int IdxW = $clog2(NUM_LINES)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wbMode,
  input  logic            cpuValid,
  input  logic            cpuWrite,
  input  logic            flushReq,
  input  logic            hit,
  input  logic            victimDirty,
  input  logic            memAck,
  output dp_strobe_t      strobe,
  output logic            selFlush,
  output logic [IdxW-1:0] flushIdx,
  output logic            cpuReady,
  output logic            memReq,
  output memop_e          memOp,
  output logic            flushDone
);

  localparam logic [IdxW-1:0] LastIdx = IdxW'(NUM_LINES - 1);

  state_e state, nextState;
  logic   wtDone;
  logic   flushActive;

  always_comb begin
    nextState = state;
    strobe    = '0;
    selFlush  = 1'b0;
    cpuReady  = 1'b0;
    memReq    = 1'b0;
    memOp     = MEM_LINE_RD;
    flushDone = 1'b0;
    case (state)
      ST_IDLE: begin
        if (flushReq)      nextState = ST_FLUSH;
        else if (cpuValid) nextState = ST_COMPARE;
      end
      ST_COMPARE: begin
        if (!cpuValid) begin
          nextState = ST_IDLE;
        end else if (cpuWrite && !wbMode) begin
          if (!wtDone) begin
            nextState = ST_MEM_WRITE;
          end else begin
            strobe.mergeWord = hit;
            cpuReady  = 1'b1;
            nextState = ST_IDLE;
          end
        end else if (hit) begin
          strobe.mergeWord = cpuWrite;
          strobe.setDirty  = cpuWrite;
          cpuReady  = 1'b1;
          nextState = ST_IDLE;
        end else if (victimDirty) begin
          nextState = ST_WRITEBACK;
        end else begin
          nextState = ST_REFILL;
        end
      end
      ST_WRITEBACK: begin
        memReq   = 1'b1;
        memOp    = MEM_LINE_WR;
        selFlush = flushActive;
        if (memAck) begin
          strobe.clearDirty = 1'b1;
          nextState = flushActive ? ST_FLUSH : ST_REFILL;
        end
      end
      ST_REFILL: begin
        memReq = 1'b1;
        memOp  = MEM_LINE_RD;
        if (memAck) begin
          strobe.installLine = 1'b1;
          nextState = ST_COMPARE;
        end
      end
      ST_MEM_WRITE: begin
        memReq = 1'b1;
        memOp  = MEM_WORD_WR;
        if (memAck) nextState = ST_COMPARE;
      end
      ST_FLUSH: begin
        selFlush = 1'b1;
        if (victimDirty) begin
          nextState = ST_WRITEBACK;
        end else if (flushIdx == LastIdx) begin
          flushDone = 1'b1;
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      wtDone      <= 1'b0;
      flushActive <= 1'b0;
      flushIdx    <= '0;
    end else begin
      state <= nextState;
      if (state == ST_MEM_WRITE && memAck) wtDone <= 1'b1;
      else if (cpuReady)                   wtDone <= 1'b0;
      if (state == ST_IDLE && flushReq) begin
        flushActive <= 1'b1;
        flushIdx    <= '0;
      end else if (flushDone) begin
        flushActive <= 1'b0;
      end else if (state == ST_FLUSH && !victimDirty) begin
        flushIdx <= flushIdx + 1'b1;
      end
    end
  end

  AST_READY_NO_MEM: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> !memReq);  // R11
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memOp));  // R11
  AST_WB_NO_WORD_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    memReq && wbMode |-> memOp != MEM_WORD_WR);  // R3
  AST_WT_NEVER_DIRTY: assert property (@(posedge clk) disable iff (!rstN)
    !wbMode |-> !victimDirty);  // R2
  AST_FETCH_AFTER_WB: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memOp == MEM_LINE_RD |-> !victimDirty);  // R4
  AST_FLUSH_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    flushDone |=> !flushDone);  // R10

endmodule

// File: rtl/dcache_ctrl.sv
module dcache_ctrl
  import dcache_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int NUM_LINES  = 16,
  localparam int BeW   = WORD_W / 8,
  localparam int WselW = $clog2(LINE_WORDS),
  localparam int IdxW  = $clog2(NUM_LINES),
  localparam int LineW = WORD_W * LINE_WORDS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wbMode,
  input  logic              cpuValid,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [WORD_W-1:0] cpuWdata,
  input  logic [BeW-1:0]    cpuBe,
  output logic              cpuReady,
  output logic [WORD_W-1:0] cpuRdata,
  input  logic              flushReq,
  output logic              flushDone,
  output logic              memReq,
  output logic [1:0]        memOp,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LineW-1:0]  memWline,
  output logic [WORD_W-1:0] memWword,
  output logic [BeW-1:0]    memBe,
  input  logic              memAck,
  input  logic [LineW-1:0]  memRline
);

  dp_strobe_t        strobe;
  logic              selFlush;
  logic [IdxW-1:0]   flushIdx;
  logic              hit;
  logic              victimDirty;
  logic [ADDR_W-1:0] victimAddr;
  memop_e            memOpE;

  dcache_ctl #(.NUM_LINES(NUM_LINES)) u_ctl (
    .clk(clk), .rstN(rstN), .wbMode(wbMode),
    .cpuValid(cpuValid), .cpuWrite(cpuWrite), .flushReq(flushReq),
    .hit(hit), .victimDirty(victimDirty), .memAck(memAck),
    .strobe(strobe), .selFlush(selFlush), .flushIdx(flushIdx),
    .cpuReady(cpuReady), .memReq(memReq), .memOp(memOpE), .flushDone(flushDone)
  );

  dcache_dp #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS), .NUM_LINES(NUM_LINES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .selFlush(selFlush), .flushIdx(flushIdx),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuBe(cpuBe), .memRline(memRline),
    .hit(hit), .victimDirty(victimDirty), .victimAddr(victimAddr),
    .lineData(memWline), .rdWord(cpuRdata)
  );

  always_comb begin
    case (memOpE)
      MEM_LINE_WR: memAddr = victimAddr;
      MEM_LINE_RD: memAddr = {cpuAddr[ADDR_W-1:WselW], {WselW{1'b0}}};
      default:     memAddr = cpuAddr;
    endcase
  end

  assign memOp    = memOpE;
  assign memWword = cpuWdata;
  assign memBe    = cpuBe;

endmodule

// File: tb/dcache_ctrl_tb.sv
`timescale 1ns/1ps
module dcache_ctrl_tb;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wbMode = 1'b1;
  logic         cpuValid = 1'b0;
  logic         cpuWrite = 1'b0;
  logic [9:0]   cpuAddr = '0;
  logic [31:0]  cpuWdata = '0;
  logic [3:0]   cpuBe = '0;
  logic         cpuReady;
  logic [31:0]  cpuRdata;
  logic         flushReq = 1'b0;
  logic         flushDone;
  logic         memReq;
  logic [1:0]   memOp;
  logic [9:0]   memAddr;
  logic [127:0] memWline;
  logic [31:0]  memWword;
  logic [3:0]   memBe;
  logic         memAck = 1'b0;
  logic [127:0] memRline = '0;

  int checks = 0;
  int failures = 0;
  bit timedOut = 0;

  always #2.5 clk = ~clk;

  dcache_ctrl u_dut (
    .clk(clk), .rstN(rstN), .wbMode(wbMode), .cpuValid(cpuValid), .cpuWrite(cpuWrite),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuBe(cpuBe), .cpuReady(cpuReady),
    .cpuRdata(cpuRdata), .flushReq(flushReq), .flushDone(flushDone), .memReq(memReq),
    .memOp(memOp), .memAddr(memAddr), .memWline(memWline), .memWword(memWword),
    .memBe(memBe), .memAck(memAck), .memRline(memRline)
  );

  // Memory model with operation log
  logic [31:0] mem [0:1023];
  logic [1:0]  logOp   [0:7];
  logic [9:0]  logAddr [0:7];
  int logN = 0;
  int waitCnt = 0;

  function automatic logic [31:0] initVal(int i);
    return 32'h5A00_0000 + i * 32'h0001_0103;
  endfunction

  function automatic logic [9:0] wa(logic [3:0] tag, logic [3:0] idx, logic [1:0] w);
    return {tag, idx, w};
  endfunction

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = initVal(i);
    forever begin
      @(negedge clk);
      if (!rstN) begin
        memAck = 1'b0;
        waitCnt = 0;
      end else if (memAck) begin
        memAck = 1'b0;
      end else if (memReq) begin
        if (waitCnt == 1) begin
          if (logN < 8) begin
            logOp[logN] = memOp;
            logAddr[logN] = memAddr;
          end
          logN++;
          case (memOp)
            2'd0: for (int w = 0; w < 4; w++) memRline[w*32 +: 32] = mem[int'(memAddr) + w];
            2'd1: for (int w = 0; w < 4; w++) mem[int'(memAddr) + w] = memWline[w*32 +: 32];
            default: for (int b = 0; b < 4; b++)
              if (memBe[b]) mem[int'(memAddr)][b*8 +: 8] = memWword[b*8 +: 8];
          endcase
          memAck = 1'b1;
          waitCnt = 0;
        end else begin
          waitCnt++;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic mode);
    @(negedge clk);
    rstN = 1'b0;
    wbMode = mode;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic cpuOp(input logic wr, input logic [9:0] a, input logic [31:0] wd,
                       input logic [3:0] be, output logic [31:0] rd, output int lat);
    @(negedge clk);
    cpuValid = 1'b1; cpuWrite = wr; cpuAddr = a; cpuWdata = wd; cpuBe = be;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!cpuReady && !timedOut);
    rd = cpuRdata;
    @(negedge clk);
    cpuValid = 1'b0;
  endtask

  task automatic doFlush(output int pulses);
    @(negedge clk);
    flushReq = 1'b1;
    @(negedge clk);
    flushReq = 1'b0;
    pulses = 0;
    for (int c = 0; c < 200; c++) begin
      if (flushDone) pulses++;
      @(negedge clk);
    end
  endtask

  logic [31:0] rd, expv;
  int lat, pulses;

  task automatic testReset();
    doReset(1'b1);
    chk("R11 cpuReady low after reset", 32'(cpuReady), 0);
    chk("R11 memReq low after reset", 32'(memReq), 0);
    chk("R11 flushDone low after reset", 32'(flushDone), 0);
  endtask

  task automatic testReadMissHit();
    logN = 0;
    cpuOp(0, wa(1, 3, 2), 0, 0, rd, lat);
    chk("R5 cold miss data", rd, initVal(wa(1, 3, 2)));
    chk("R5 cold miss op count", logN, 1);
    chk("R5 cold miss op is line read", 32'(logOp[0]), 0);
    chk("R5 cold miss line address", 32'(logAddr[0]), 32'(wa(1, 3, 0)));
    chk("R11 ready withheld during refill", 32'(lat > 1), 1);
    logN = 0;
    cpuOp(0, wa(1, 3, 2), 0, 0, rd, lat);
    chk("R1 hit data", rd, initVal(wa(1, 3, 2)));
    chk("R1 hit latency", lat, 1);
    chk("R1 hit no memory traffic", logN, 0);
  endtask

  task automatic testWbWriteHit();
    logN = 0;
    cpuOp(1, wa(1, 3, 2), 32'h1122_3344, 4'b0101, rd, lat);
    chk("R3 write hit latency", lat, 1);
    chk("R3 write hit no memory traffic", logN, 0);
    cpuOp(0, wa(1, 3, 2), 0, 0, rd, lat);
    expv = (initVal(wa(1, 3, 2)) & 32'hFF00_FF00) | 32'h0022_0044;
    chk("R9 partial merge into cached word", rd, expv);
    chk("R3 memory unchanged after write hit", mem[wa(1, 3, 2)], initVal(wa(1, 3, 2)));
  endtask

  task automatic testAbsorbEvict();
    logN = 0;
    for (int k = 1; k <= 3; k++) cpuOp(1, wa(1, 3, 2), 32'(k), 4'hF, rd, lat);
    chk("R8 repeated writes no traffic", logN, 0);
    cpuOp(0, wa(2, 3, 0), 0, 0, rd, lat);
    chk("R4 dirty miss op count", logN, 2);
    chk("R4 first op is line write", 32'(logOp[0]), 1);
    chk("R4 victim line address", 32'(logAddr[0]), 32'(wa(1, 3, 0)));
    chk("R4 second op is line read", 32'(logOp[1]), 0);
    chk("R4 fetch line address", 32'(logAddr[1]), 32'(wa(2, 3, 0)));
    chk("R8 final value reaches memory", mem[wa(1, 3, 2)], 32'd3);
    chk("R8 untouched word of victim", mem[wa(1, 3, 1)], initVal(wa(1, 3, 1)));
    chk("R4 new line data", rd, initVal(wa(2, 3, 0)));
    logN = 0;
    cpuOp(0, wa(5, 3, 1), 0, 0, rd, lat);
    chk("R5 clean victim op count", logN, 1);
    chk("R5 clean victim op is line read", 32'(logOp[0]), 0);
  endtask

  task automatic testWbWriteMiss();
    logN = 0;
    cpuOp(1, wa(3, 7, 1), 32'hDEAD_BEEF, 4'b1100, rd, lat);
    chk("R6 write miss op count", logN, 1);
    chk("R6 write miss op is line read", 32'(logOp[0]), 0);
    chk("R6 memory not written", mem[wa(3, 7, 1)], initVal(wa(3, 7, 1)));
    logN = 0;
    cpuOp(0, wa(3, 7, 1), 0, 0, rd, lat);
    expv = (initVal(wa(3, 7, 1)) & 32'h0000_FFFF) | 32'hDEAD_0000;
    chk("R6 merged word after allocate", rd, expv);
    chk("R6 allocated line hits", lat, 1);
  endtask

  task automatic testFlushWb();
    cpuOp(1, wa(4, 9, 0), 32'h0BAD_CAFE, 4'hF, rd, lat);
    logN = 0;
    doFlush(pulses);
    chk("R10 one done pulse", pulses, 1);
    chk("R10 dirty lines written", logN, 2);
    chk("R10 first writeback op", 32'(logOp[0]), 1);
    chk("R10 first writeback address", 32'(logAddr[0]), 32'(wa(3, 7, 0)));
    chk("R10 second writeback op", 32'(logOp[1]), 1);
    chk("R10 second writeback address", 32'(logAddr[1]), 32'(wa(4, 9, 0)));
    expv = (initVal(wa(3, 7, 1)) & 32'h0000_FFFF) | 32'hDEAD_0000;
    chk("R10 flushed data in memory", mem[wa(3, 7, 1)], expv);
    chk("R10 second flushed data", mem[wa(4, 9, 0)], 32'h0BAD_CAFE);
    logN = 0;
    doFlush(pulses);
    chk("R10 repeat flush pulse", pulses, 1);
    chk("R10 repeat flush no traffic", logN, 0);
    cpuOp(0, wa(3, 7, 1), 0, 0, rd, lat);
    chk("R10 line still valid after flush", logN, 0);
    cpuOp(0, wa(6, 7, 0), 0, 0, rd, lat);
    chk("R10 flushed victim is clean", logN, 1);
    chk("R10 clean victim op is line read", 32'(logOp[0]), 0);
  endtask

  task automatic testWtWrites();
    doReset(1'b0);
    cpuOp(0, wa(1, 2, 0), 0, 0, rd, lat);
    chk("R5 write-through fill data", rd, mem[wa(1, 2, 0)]);
    logN = 0;
    cpuOp(1, wa(1, 2, 0), 32'h1357_9BDF, 4'hF, rd, lat);
    chk("R2 write hit op count", logN, 1);
    chk("R2 write hit op is word write", 32'(logOp[0]), 2);
    chk("R2 word write address", 32'(logAddr[0]), 32'(wa(1, 2, 0)));
    chk("R2 memory updated", mem[wa(1, 2, 0)], 32'h1357_9BDF);
    logN = 0;
    cpuOp(0, wa(1, 2, 0), 0, 0, rd, lat);
    chk("R2 cached copy updated", rd, 32'h1357_9BDF);
    chk("R2 read back from cache", logN, 0);
    logN = 0;
    expv = (mem[wa(8, 2, 3)] & 32'hFFFF_0000) | 32'h0000_F00D;
    cpuOp(1, wa(8, 2, 3), 32'hCAFE_F00D, 4'b0011, rd, lat);
    chk("R7 write miss op count", logN, 1);
    chk("R7 write miss op is word write", 32'(logOp[0]), 2);
    chk("R9 direct write byte lanes", mem[wa(8, 2, 3)], expv);
    logN = 0;
    cpuOp(0, wa(1, 2, 0), 0, 0, rd, lat);
    chk("R7 resident line kept", rd, 32'h1357_9BDF);
    chk("R7 resident line still hits", logN, 0);
    cpuOp(0, wa(8, 2, 3), 0, 0, rd, lat);
    chk("R7 missed address not cached", logN, 1);
    chk("R7 later read data", rd, expv);
    logN = 0;
    cpuOp(0, wa(9, 2, 0), 0, 0, rd, lat);
    chk("R2 no writeback in write-through", logN, 1);
    chk("R2 eviction op is line read", 32'(logOp[0]), 0);
    logN = 0;
    doFlush(pulses);
    chk("R10 write-through flush pulse", pulses, 1);
    chk("R10 write-through flush no traffic", logN, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    timedOut = 1;
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    testReset();
    testReadMissHit();
    testWbWriteHit();
    testAbsorbEvict();
    testWbWriteMiss();
    testFlushWb();
    testWtWrites();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule